// File: doc/BRIEF.md
# Reference-Timed Frequency Meter

This block measures the rate of a test clock against a reference clock whose frequency is known to software in kHz. A write strobe with a nonzero source code starts a measurement. The meter first waits a programmable number of reference cycles so that an upstream clock selector can settle. It then opens a window of 2^exponent time-base ticks and counts the test-clock edges that arrive during that window. The time base ticks once every ref_khz/1024 reference cycles, which is roughly one microsecond.

The test clock runs a free Gray-coded edge counter in its own domain. A synchronizer chain carries that counter into the reference domain, where the count is snapshotted at the start and at the end of the window. The difference is scaled to kHz in fixed point with fractional bits kept, and then compared against optional lower and upper limits. The result and its flags stay valid while `done` is high. They are cleared by the next write strobe.

Top module: `freq_meter`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `pass`, `fast` and `slow` are 0 and `res_khz` is 0.
- R2: A write strobe (`src_wr`=1) with a nonzero `src_sel` is sampled at a reference edge. From the next cycle on, `busy` is 1 and `done`, `pass`, `fast`, `slow` and `res_khz` are 0. The configuration inputs are captured at that same edge.
- R3: A write strobe with `src_sel`=0 means no clock is under test. It aborts any running measurement: from the next cycle `busy` and `done` are 0, and no result appears afterwards.
- R4: `busy` stays high for exactly settle + D·2^exp + 2 reference cycles. Here D = max(ref_khz>>10, 1), settle is `settle_cyc` and exp is `win_exp`. `done` rises in the cycle in which `busy` falls.
- R5: `res_khz` holds the window edge count × 1024 / 2^exp in fixed point. The low FRAC_W (default 5) bits are the fraction and the upper 25 bits are integer kHz. The value saturates to all ones on overflow. It matches the true rate to within two edges of window quantization.
- R6: When measurement ends with lo ≤ integer kHz ≤ hi (with each check enabled), `pass` is set together with `done`.
- R7: `slow` is set instead of `pass` when the integer kHz is below `lim_lo_khz`. A `lim_lo_khz` of 0 disables this check.
- R8: `fast` is set instead of `pass` when the integer kHz is above `lim_hi_khz`. A `lim_hi_khz` of 0x1FFFFFF (all ones) disables this check.
- R9: Once `done` is set, `done`, the flags and `res_khz` hold their values until the next write strobe.
- R10: At most one of `pass`, `fast` and `slow` is set, and none of them is set without `done`. `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, clocks all control logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_test | input | 1 | Clock under measurement |
| src_wr | input | 1 | Write strobe for the source select; starts or aborts a measurement |
| src_sel | input | 4 | Source code; 0 means no clock under test |
| ref_khz | input | 20 | Reference frequency in kHz |
| lim_lo_khz | input | 25 | Lower pass limit in kHz, 0 disables |
| lim_hi_khz | input | 25 | Upper pass limit in kHz, all ones disables |
| settle_cyc | input | 8 | Settle delay in reference cycles before counting |
| win_exp | input | 4 | Window length exponent, window = 2^win_exp ticks |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Result valid |
| pass | output | 1 | Result within limits |
| fast | output | 1 | Result above upper limit |
| slow | output | 1 | Result below lower limit |
| res_khz | output | 30 | Measured frequency, 25.5 fixed point kHz |

## Verification
The bound assertions check the control contract on every cycle. A nonzero write leads to a busy, cleared state and a zero write leads to an idle one. A finished result holds steady until the next write. The pass, fast and slow flags are mutually exclusive, are gated by `done`, and never overlap with `busy`. The exact window length, the scaled kHz value for a range of clock ratios and window exponents, and the way each limit is compared or disabled depend on real clock stimulus. Only the bench's scenarios can show them, and it also covers the divider floor of one for a reference below 1024 kHz and an abort that occurs in the middle of the window.

// File: rtl/fm_pkg.sv
package fm_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_COUNT  = 2'd2,
      ST_FINISH = 2'd3
   } fm_state_e;

   // time-base ticks are ref_khz >> TB_SHIFT reference cycles long
   localparam int TB_SHIFT = 10;

endpackage

// File: rtl/fm_edge_xing.sv
// Test-domain edge counter carried into the reference domain as Gray code.
module fm_edge_xing #(
   parameter int CNT_W       = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_test,
   input  logic             clk_ref,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt_ref
);

   logic [CNT_W-1:0] bin_q;
   logic [CNT_W-1:0] bin_nx;
   logic [CNT_W-1:0] gray_q;

   assign bin_nx = bin_q + 1'b1;

   always_ff @(posedge clk_test or negedge rst_n) begin
      if (!rst_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   logic [CNT_W-1:0] stage_q [SYNC_STAGES];

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= gray_q;
         end
      end else begin : g_next
         always_ff @(posedge clk_ref or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   always_comb begin
      for (int i = 0; i < CNT_W; i++) begin
         cnt_ref[i] = ^(stage_q[SYNC_STAGES-1] >> i);
      end
   end

endmodule

// File: rtl/fm_timebase.sv
// Microsecond-ish tick divider and window-length counter.
module fm_timebase #(
   parameter int DIV_W = 10,
   parameter int EXP_W = 4
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_raw,
   input  logic [EXP_W-1:0] win_exp,
   output logic             win_end
);

   localparam int TICK_W = 2 ** EXP_W;

   logic [DIV_W-1:0]  div_eff;
   logic [DIV_W-1:0]  div_cnt_q;
   logic [TICK_W-1:0] tick_cnt_q;
   logic [TICK_W-1:0] tick_last;
   logic              tick;

   assign div_eff   = (div_raw == '0) ? DIV_W'(1) : div_raw;
   assign tick      = run && (div_cnt_q == div_eff - 1'b1);
   assign tick_last = (TICK_W'(1) << win_exp) - 1'b1;
   assign win_end   = tick && (tick_cnt_q == tick_last);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt_q  <= '0;
         tick_cnt_q <= '0;
      end else if (!run) begin
         div_cnt_q  <= '0;
         tick_cnt_q <= '0;
      end else if (tick) begin
         div_cnt_q  <= '0;
         tick_cnt_q <= tick_cnt_q + 1'b1;
      end else begin
         div_cnt_q  <= div_cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/fm_scale.sv
// Converts a window edge count to fixed-point kHz and grades it against limits.
module fm_scale #(
   parameter int CNT_W    = 24,
   parameter int EXP_W    = 4,
   parameter int KHZ_W    = 25,
   parameter int FRAC_W   = 5,
   parameter bit SATURATE = 1'b1
) (
   input  logic [CNT_W-1:0]        edges,
   input  logic [EXP_W-1:0]        win_exp,
   input  logic [KHZ_W-1:0]        lim_lo,
   input  logic [KHZ_W-1:0]        lim_hi,
   output logic [KHZ_W+FRAC_W-1:0] res,
   output logic                    pass,
   output logic                    fast,
   output logic                    slow
);

   localparam int SH     = fm_pkg::TB_SHIFT + FRAC_W;
   localparam int WIDE_W = CNT_W + SH;
   localparam int RES_W  = KHZ_W + FRAC_W;
   localparam logic [KHZ_W-1:0] HI_OFF = '1;

   logic [WIDE_W-1:0] wide;
   logic [KHZ_W-1:0]  int_khz;

   assign wide = {edges, {SH{1'b0}}} >> win_exp;

   if (SATURATE) begin : g_sat
      assign res = (|wide[WIDE_W-1:RES_W]) ? {RES_W{1'b1}} : wide[RES_W-1:0];
   end else begin : g_trunc
      assign res = wide[RES_W-1:0];
   end

   assign int_khz = res[RES_W-1:FRAC_W];
   assign slow    = (lim_lo != '0) && (int_khz < lim_lo);
   assign fast    = (lim_hi != HI_OFF) && (int_khz > lim_hi);
   assign pass    = !slow && !fast;

endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
   parameter int SRC_W       = 4,
   parameter int REF_W       = 20,
   parameter int KHZ_W       = 25,
   parameter int FRAC_W      = 5,
   parameter int CNT_W       = 24,
   parameter int EXP_W       = 4,
   parameter int SETTLE_W    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit SATURATE    = 1'b1
) (
   input  logic                    clk_ref,
   input  logic                    rst_n,
   input  logic                    clk_test,
   input  logic                    src_wr,
   input  logic [SRC_W-1:0]        src_sel,
   input  logic [REF_W-1:0]        ref_khz,
   input  logic [KHZ_W-1:0]        lim_lo_khz,
   input  logic [KHZ_W-1:0]        lim_hi_khz,
   input  logic [SETTLE_W-1:0]     settle_cyc,
   input  logic [EXP_W-1:0]        win_exp,
   output logic                    busy,
   output logic                    done,
   output logic                    pass,
   output logic                    fast,
   output logic                    slow,
   output logic [KHZ_W+FRAC_W-1:0] res_khz
);

   import fm_pkg::*;

   localparam int DIV_W = REF_W - TB_SHIFT;
   localparam int RES_W = KHZ_W + FRAC_W;

   if (REF_W <= TB_SHIFT) begin : g_bad_ref
      $error("freq_meter: REF_W must exceed the time-base shift");
   end
   if (CNT_W + TB_SHIFT <= KHZ_W) begin : g_bad_cnt
      $error("freq_meter: CNT_W too narrow for KHZ_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("freq_meter: at least two synchronizer stages required");
   end

   fm_state_e         state_q;
   logic [REF_W-1:0]  ref_q;
   logic [KHZ_W-1:0]  lo_q;
   logic [KHZ_W-1:0]  hi_q;
   logic [EXP_W-1:0]  exp_q;
   logic [SETTLE_W-1:0] settle_q;
   logic [CNT_W-1:0]  start_q;
   logic [CNT_W-1:0]  edges_q;
   logic [CNT_W-1:0]  cnt_ref;
   logic              win_end;
   logic [RES_W-1:0]  sc_res;
   logic              sc_pass;
   logic              sc_fast;
   logic              sc_slow;

   fm_edge_xing #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_xing (
      .clk_test (clk_test),
      .clk_ref  (clk_ref),
      .rst_n    (rst_n),
      .cnt_ref  (cnt_ref)
   );

   fm_timebase #(
      .DIV_W (DIV_W),
      .EXP_W (EXP_W)
   ) u_tb (
      .clk_ref (clk_ref),
      .rst_n   (rst_n),
      .run     (state_q == ST_COUNT),
      .div_raw (ref_q[REF_W-1:TB_SHIFT]),
      .win_exp (exp_q),
      .win_end (win_end)
   );

   fm_scale #(
      .CNT_W    (CNT_W),
      .EXP_W    (EXP_W),
      .KHZ_W    (KHZ_W),
      .FRAC_W   (FRAC_W),
      .SATURATE (SATURATE)
   ) u_scale (
      .edges   (edges_q),
      .win_exp (exp_q),
      .lim_lo  (lo_q),
      .lim_hi  (hi_q),
      .res     (sc_res),
      .pass    (sc_pass),
      .fast    (sc_fast),
      .slow    (sc_slow)
   );

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         ref_q    <= '0;
         lo_q     <= '0;
         hi_q     <= '0;
         exp_q    <= '0;
         settle_q <= '0;
         start_q  <= '0;
         edges_q  <= '0;
         done     <= 1'b0;
         pass     <= 1'b0;
         fast     <= 1'b0;
         slow     <= 1'b0;
         res_khz  <= '0;
      end else if (src_wr) begin
         done    <= 1'b0;
         pass    <= 1'b0;
         fast    <= 1'b0;
         slow    <= 1'b0;
         res_khz <= '0;
         if (src_sel != '0) begin
            ref_q    <= ref_khz;
            lo_q     <= lim_lo_khz;
            hi_q     <= lim_hi_khz;
            exp_q    <= win_exp;
            settle_q <= settle_cyc;
            state_q  <= ST_SETTLE;
         end else begin
            state_q  <= ST_IDLE;
         end
      end else begin
         unique case (state_q)
            ST_SETTLE: begin
               if (settle_q == '0) begin
                  start_q <= cnt_ref;
                  state_q <= ST_COUNT;
               end else begin
                  settle_q <= settle_q - 1'b1;
               end
            end
            ST_COUNT: begin
               if (win_end) begin
                  edges_q <= cnt_ref - start_q;
                  state_q <= ST_FINISH;
               end
            end
            ST_FINISH: begin
               res_khz <= sc_res;
               pass    <= sc_pass;
               fast    <= sc_fast;
               slow    <= sc_slow;
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
   parameter int SRC_W = 4,
   parameter int RES_W = 30
) (
   input logic             clk_ref,
   input logic             rst_n,
   input logic             src_wr,
   input logic [SRC_W-1:0] src_sel,
   input logic             busy,
   input logic             done,
   input logic             pass,
   input logic             fast,
   input logic             slow,
   input logic [RES_W-1:0] res_khz
);

   a_r2_start_clears: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (src_wr && src_sel != '0) |=> (busy && !done && !pass && !fast && !slow && res_khz == '0));

   a_r3_abort_idle: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (src_wr && src_sel == '0) |=> (!busy && !done));

   a_r9_result_held: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (done && !src_wr) |=> (done && $stable(res_khz) && $stable({pass, fast, slow})));

   a_r10_flags_onehot: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $onehot0({pass, fast, slow}));

   a_r10_flags_need_done: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (pass || fast || slow) |-> done);

   a_r10_busy_done_excl: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !(busy && done));

   a_r6_done_graded: assert property (@(posedge clk_ref) disable iff (!rst_n)
      $rose(done) |-> $countones({pass, fast, slow}) == 1);

endmodule

bind freq_meter fm_checker #(
   .SRC_W (SRC_W),
   .RES_W (KHZ_W + FRAC_W)
) u_fm_chk (
   .clk_ref (clk_ref),
   .rst_n   (rst_n),
   .src_wr  (src_wr),
   .src_sel (src_sel),
   .busy    (busy),
   .done    (done),
   .pass    (pass),
   .fast    (fast),
   .slow    (slow),
   .res_khz (res_khz)
);

// File: tb/tb_freq_meter.sv
`timescale 1ns/1ps
module tb_freq_meter;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;
   localparam logic [24:0] HI_OFF = 25'h1FFFFFF;

   // vector table: test period (ns), exponent, settle, lo, hi, expected grade (0 pass, 1 slow, 2 fast)
   localparam int V_TP  [NV] = '{20, 8, 40, 6, 14, 10, 40, 5};
   localparam int V_EXP [NV] = '{4, 3, 5, 2, 6, 4, 3, 3};
   localparam int V_SET [NV] = '{3, 5, 1, 0, 7, 2, 4, 0};
   localparam int V_LO  [NV] = '{0, 4000, 2000, 0, 0, 1, 0, 0};
   localparam int V_HI  [NV] = '{33554431, 6000, 33554431, 3000, 33554431, 33554430, 2000, 33554431};
   localparam int V_GR  [NV] = '{0, 0, 1, 2, 0, 0, 0, 0};

   logic        clk_ref = 1'b0;
   logic        clk_test = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_wr = 1'b0;
   logic [3:0]  src_sel = '0;
   logic [19:0] ref_khz = 20'd4096;
   logic [24:0] lim_lo_khz = '0;
   logic [24:0] lim_hi_khz = HI_OFF;
   logic [7:0]  settle_cyc = '0;
   logic [3:0]  win_exp = '0;
   logic        busy, done, pass, fast, slow;
   logic [29:0] res_khz;

   real tp_ns = 20.0;
   int  n_chk = 0;
   int  n_fail = 0;

   freq_meter dut (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .clk_test   (clk_test),
      .src_wr     (src_wr),
      .src_sel    (src_sel),
      .ref_khz    (ref_khz),
      .lim_lo_khz (lim_lo_khz),
      .lim_hi_khz (lim_hi_khz),
      .settle_cyc (settle_cyc),
      .win_exp    (win_exp),
      .busy       (busy),
      .done       (done),
      .pass       (pass),
      .fast       (fast),
      .slow       (slow),
      .res_khz    (res_khz)
   );

   always #(CLK_PERIOD / 2.0) clk_ref = ~clk_ref;
   initial forever #(tp_ns / 2.0) clk_test = ~clk_test;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   // issue a write strobe at a negedge; returns at the following negedge
   task automatic write_src(input logic [3:0] s);
      src_sel = s;
      src_wr  = 1'b1;
      @(negedge clk_ref);
      src_wr  = 1'b0;
   endtask

   // counts negedges with busy high, starting from the current one
   task automatic wait_idle(output int cyc);
      cyc = 0;
      while (busy && cyc < 100000) begin
         cyc++;
         @(negedge clk_ref);
      end
   endtask

   task automatic run_case(input int tp, input int ex, input int st, input int lo, input int hi,
                           input int grade, input int rk);
      int cyc;
      int div;
      int w;
      longint edges;
      longint exp_khz;
      longint tol;
      longint act_khz;
      logic [29:0] held;
      tp_ns      = real'(tp);
      ref_khz    = 20'(rk);
      win_exp    = 4'(ex);
      settle_cyc = 8'(st);
      lim_lo_khz = 25'(lo);
      lim_hi_khz = 25'(hi);
      repeat (5) @(negedge clk_ref);
      div = (rk >> 10) == 0 ? 1 : (rk >> 10);
      w   = div * (1 << ex);
      write_src(4'd3);
      // R2: busy and cleared results right after a nonzero write
      check(busy == 1'b1 && done == 1'b0 && res_khz == '0, "R2", {busy, done}, 2);
      wait_idle(cyc);
      // R4: exact busy duration
      check(cyc == st + w + 2, "R4", cyc, st + w + 2);
      check(done == 1'b1, "R4 done", done, 1);
      edges   = longint'(w * CLK_PERIOD / tp);
      exp_khz = (edges * 1024) >>> ex;
      tol     = 2 * (1024 >>> ex) + 1;
      act_khz = longint'(res_khz[29:5]);
      // R5: scaled result within window quantization
      check(act_khz >= exp_khz - tol && act_khz <= exp_khz + tol, "R5", act_khz, exp_khz);
      if (grade == 0)      check(pass && !fast && !slow, "R6", {pass, fast, slow}, 3'b100);
      else if (grade == 1) check(slow && !pass && !fast, "R7", {pass, fast, slow}, 3'b001);
      else                 check(fast && !pass && !slow, "R8", {pass, fast, slow}, 3'b010);
      held = res_khz;
      repeat (20) @(negedge clk_ref);
      // R9: result held until the next write
      check(done && res_khz == held, "R9", res_khz, held);
   endtask

   initial begin
      int cyc;
      repeat (3) @(negedge clk_ref);
      // R1: state during reset
      check({busy, done, pass, fast, slow} == 5'b0 && res_khz == '0, "R1 in reset",
            {busy, done, pass, fast, slow}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk_ref);
      check({busy, done, pass, fast, slow} == 5'b0 && res_khz == '0, "R1 after reset",
            {busy, done, pass, fast, slow}, 0);

      for (int i = 0; i < NV; i++) begin
         run_case(V_TP[i], V_EXP[i], V_SET[i], V_LO[i], V_HI[i], V_GR[i], 4096);
      end

      // R4 with reference below 1024 kHz: divider floors at one cycle
      run_case(10, 3, 2, 0, 33554431, 0, 100);

      // R3: abort in the middle of the window
      tp_ns      = 10.0;
      ref_khz    = 20'd4096;
      win_exp    = 4'd6;
      settle_cyc = 8'd2;
      lim_lo_khz = '0;
      lim_hi_khz = HI_OFF;
      write_src(4'd1);
      repeat (30) @(negedge clk_ref);
      write_src(4'd0);
      check(!busy && !done, "R3 abort", {busy, done}, 0);
      repeat (400) @(negedge clk_ref);
      check(!busy && !done && !pass && res_khz == '0, "R3 no result",
            {busy, done, pass}, 0);

      // R3: zero write after a completed run clears done
      run_case(20, 2, 1, 0, 33554431, 0, 4096);
      write_src(4'd0);
      check(!done && !pass && res_khz == '0, "R3 clear done", {done, pass}, 0);

      // R2: restart while a result is pending clears it before the new result
      run_case(8, 2, 0, 0, 33554431, 0, 4096);
      win_exp = 4'd4;
      write_src(4'd2);
      check(busy && !done && !pass, "R2 restart", {busy, done, pass}, 3'b100);
      wait_idle(cyc);
      check(cyc == 0 + 64 + 2, "R4 restart", cyc, 66);

      finish_run();
   end

endmodule